// File: doc/BRIEF.md
# Three-Level Space Vector Sequence Selector

This block produces the switching-state pattern for one period of a three-phase, three-level converter. An upstream stage supplies four things. The first is a reference angle that has already been folded into the first 60-degree sector. The second is the on-times of the three discrete vectors nearest that reference. The third is a signed measure of the DC-link midpoint unbalance, defined as upper-capacitor voltage minus lower-capacitor voltage. The fourth is a pair of programmable hysteresis thresholds. The block plays out a symmetric five-segment pattern with outer, inner, middle, inner and outer segments. Each segment drives a three-phase state in which every phase is positive, zero or negative.

Two candidate sequences exist. Both share the middle vector, and their redundant small vectors push midpoint current in opposite directions.
- In the first half of the sector, the angle picks the sequence that holds phase A at the positive rail, which gives optimal clamping.
- In the second half of the sector, the angle picks the sequence that holds phase C at the negative rail.
- A hysteresis comparator on the unbalance can override that choice, because balancing takes precedence over clamping.

The sequence and the segment lengths are captured once, at the start of each period. The periods follow one another with no gap.

Top module: `svm3_seq_sel`

## Requirements
- R1: Each phase output is coded in two bits: `01` means +1, `00` means 0 and `11` means -1. The code `10` never appears.
- R2: With `seq_sel` = 0, which charges the upper capacitor, segments 0..4 carry (+,+,0), (+,0,0), (+,0,-), (+,0,0), (+,+,0) on phases (A,B,C).
- R3: With `seq_sel` = 1, which charges the lower capacitor, segments 0..4 carry (0,-,-), (0,0,-), (+,0,-), (0,0,-), (0,-,-) on phases (A,B,C).
- R4: When no balancing override is active, the block selects `seq_sel` = 0 if `angle` is below half of full scale (MSB clear, 0 to 30 degrees). Otherwise it selects `seq_sel` = 1.
- R5: An unbalance strictly below `thr_lo` forces `seq_sel` = 0, and an unbalance strictly above `thr_hi` forces `seq_sel` = 1, whatever the angle. A value equal to a threshold does not trigger the override.
- R6: A forced upper-charge choice holds while the unbalance stays below zero, and a forced lower-charge choice holds while it stays above zero. Once the hold condition fails, the choice returns to the angle rule.
- R7: Segment lengths in clock cycles are `t_a>>1`, `t_b>>1`, `t_c`, `t_b>>1` and `t_a>>1`. A middle segment with `t_c` = 0 lasts one cycle. Segments of zero length are skipped, and `seg_idx` reports the segment number (0..4).
- R8: `angle`, the on-times, the unbalance and the thresholds are sampled only on the clock edge that opens a period. Changes made during a period do not affect that period.
- R9: `period_start` is high exactly in the first cycle of each period, and a new period begins in the cycle after the last segment ends.
- R10: While `rst` is high, all phases read `00`, `seg_idx` and `seq_sel` read 0, and `period_start` is low. The hysteresis returns to the angle rule. The first period opens in the first cycle after `rst` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| angle | input | AW | Angle within the sector; full scale is 60 degrees |
| t_a | input | TW | On-time of the outer vector pair, in cycles |
| t_b | input | TW | On-time of the inner vector pair, in cycles |
| t_c | input | TW | On-time of the middle vector, in cycles |
| unbal | input | UW | Signed midpoint unbalance (upper minus lower) |
| thr_lo | input | UW | Signed lower hysteresis threshold |
| thr_hi | input | UW | Signed upper hysteresis threshold |
| phase_a | output | 2 | Phase A state code |
| phase_b | output | 2 | Phase B state code |
| phase_c | output | 2 | Phase C state code |
| seg_idx | output | 3 | Current segment number |
| period_start | output | 1 | High in the first cycle of a period |
| seq_sel | output | 1 | Sequence in use: 0 charges upper, 1 charges lower |

## Verification
The checker enforces several properties on every cycle:
- No phase code is ever illegal.
- The middle segment always carries the shared vector.
- The clamped phase stays at its rail for the selected sequence.
- The selection cannot move within a period.
- Segments only advance within a period.
- A period opens on segment 0, 1 or 2.

Other behaviour can only be shown by the bench's scenarios. This covers the exact segment lengths and skipping, and which sequence the angle and thresholds select, including values equal to a threshold. It also covers hysteresis hold and release across consecutive periods, the absence of any effect from inputs changed mid-period, and the return of the hysteresis to the angle rule after reset.

// File: rtl/svm3_pkg.sv
package svm3_pkg;

    localparam int NSEG  = 5;
    localparam int SEG_W = 3;

    typedef enum logic [1:0] {
        PH_ZERO = 2'b00,
        PH_POS  = 2'b01,
        PH_NEG  = 2'b11
    } phase_e;

    typedef struct packed {
        phase_e a;
        phase_e b;
        phase_e c;
    } vec3_t;

    typedef enum logic [1:0] {
        BAL_FOLLOW = 2'd0,
        BAL_UPPER  = 2'd1,
        BAL_LOWER  = 2'd2
    } bal_e;

    localparam vec3_t VEC_IDLE = '{a: PH_ZERO, b: PH_ZERO, c: PH_ZERO};

    // Index of the first non-empty segment at or after (incl) / after (!incl) 'from'.
    // Returns NSEG when there is none.
    function automatic logic [SEG_W-1:0] next_seg(input logic [NSEG-1:0] mask,
                                                  input logic [SEG_W-1:0] from,
                                                  input logic incl);
        logic [SEG_W-1:0] r;
        r = SEG_W'(NSEG);
        for (int i = NSEG - 1; i >= 0; i--) begin
            if (mask[i] && (incl ? (SEG_W'(i) >= from) : (SEG_W'(i) > from)))
                r = SEG_W'(i);
        end
        return r;
    endfunction

    // Three-phase state of a segment for a given sequence.
    function automatic vec3_t seg_vector(input logic sel, input logic [SEG_W-1:0] seg);
        vec3_t v;
        v = VEC_IDLE;
        case (seg)
            3'd0, 3'd4: v = sel ? '{a: PH_ZERO, b: PH_NEG,  c: PH_NEG}
                                : '{a: PH_POS,  b: PH_POS,  c: PH_ZERO};
            3'd1, 3'd3: v = sel ? '{a: PH_ZERO, b: PH_ZERO, c: PH_NEG}
                                : '{a: PH_POS,  b: PH_ZERO, c: PH_ZERO};
            3'd2:       v = '{a: PH_POS, b: PH_ZERO, c: PH_NEG};
            default:    v = VEC_IDLE;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/svm3_hyst.sv
module svm3_hyst
    import svm3_pkg::*;
#(
    parameter int UW = 10
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 load,
    input  logic                 region_hi,
    input  logic signed [UW-1:0] unbal,
    input  logic signed [UW-1:0] thr_lo,
    input  logic signed [UW-1:0] thr_hi,
    output logic                 sel_next
);

    bal_e mode_q;
    bal_e mode_n;

    always_comb begin
        if (unbal < thr_lo)
            mode_n = BAL_UPPER;
        else if (unbal > thr_hi)
            mode_n = BAL_LOWER;
        else if (mode_q == BAL_UPPER && unbal < 0)
            mode_n = BAL_UPPER;
        else if (mode_q == BAL_LOWER && unbal > 0)
            mode_n = BAL_LOWER;
        else
            mode_n = BAL_FOLLOW;
    end

    always_comb begin
        case (mode_n)
            BAL_UPPER: sel_next = 1'b0;
            BAL_LOWER: sel_next = 1'b1;
            default:   sel_next = region_hi;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            mode_q <= BAL_FOLLOW;
        else if (load)
            mode_q <= mode_n;
    end

endmodule

// File: rtl/svm3_seg_timer.sv
module svm3_seg_timer
    import svm3_pkg::*;
#(
    parameter int TW = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [TW-1:0]    t_a,
    input  logic [TW-1:0]    t_b,
    input  logic [TW-1:0]    t_c,
    output logic             load,
    output logic [SEG_W-1:0] seg_q,
    output logic             start_q,
    output logic             active_q
);

    localparam int SLOTS = 2 ** SEG_W;

    logic [TW-1:0]    dur_q [SLOTS];
    logic [TW-1:0]    dur_n [SLOTS];
    logic [TW-1:0]    cnt_q;
    logic [NSEG-1:0]  mask_q;
    logic [NSEG-1:0]  mask_n;
    logic [SEG_W-1:0] seg_after;
    logic [SEG_W-1:0] seg_first;
    logic             seg_done;

    // Fresh durations from the inputs: outer, inner, middle, inner, outer.
    always_comb begin
        for (int i = 0; i < SLOTS; i++) dur_n[i] = '0;
        dur_n[0] = t_a >> 1;
        dur_n[1] = t_b >> 1;
        dur_n[2] = (t_c == '0) ? TW'(1) : t_c;
        dur_n[3] = t_b >> 1;
        dur_n[4] = t_a >> 1;
    end

    for (genvar g = 0; g < NSEG; g++) begin : g_mask
        assign mask_q[g] = (dur_q[g] != '0);
        assign mask_n[g] = (dur_n[g] != '0);
    end

    assign seg_done  = (cnt_q == dur_q[seg_q] - TW'(1));
    assign seg_after = next_seg(mask_q, seg_q, 1'b0);
    assign seg_first = next_seg(mask_n, '0, 1'b1);
    assign load      = !active_q || (seg_done && seg_after == SEG_W'(NSEG));

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < SLOTS; i++) dur_q[i] <= '0;
            seg_q    <= '0;
            cnt_q    <= '0;
            start_q  <= 1'b0;
            active_q <= 1'b0;
        end else if (load) begin
            for (int i = 0; i < SLOTS; i++) dur_q[i] <= dur_n[i];
            seg_q    <= seg_first;
            cnt_q    <= '0;
            start_q  <= 1'b1;
            active_q <= 1'b1;
        end else if (seg_done) begin
            seg_q   <= seg_after;
            cnt_q   <= '0;
            start_q <= 1'b0;
        end else begin
            cnt_q   <= cnt_q + TW'(1);
            start_q <= 1'b0;
        end
    end

endmodule

// File: rtl/svm3_vec_map.sv
module svm3_vec_map
    import svm3_pkg::*;
(
    input  logic             active,
    input  logic             sel,
    input  logic [SEG_W-1:0] seg,
    output vec3_t            vec
);

    always_comb begin
        if (active)
            vec = seg_vector(sel, seg);
        else
            vec = VEC_IDLE;
    end

endmodule

// File: rtl/svm3_seq_sel.sv
module svm3_seq_sel
    import svm3_pkg::*;
#(
    parameter int AW = 8,
    parameter int TW = 8,
    parameter int UW = 10
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [AW-1:0]        angle,
    input  logic [TW-1:0]        t_a,
    input  logic [TW-1:0]        t_b,
    input  logic [TW-1:0]        t_c,
    input  logic signed [UW-1:0] unbal,
    input  logic signed [UW-1:0] thr_lo,
    input  logic signed [UW-1:0] thr_hi,
    output logic [1:0]           phase_a,
    output logic [1:0]           phase_b,
    output logic [1:0]           phase_c,
    output logic [2:0]           seg_idx,
    output logic                 period_start,
    output logic                 seq_sel
);

    logic             load;
    logic             sel_next;
    logic             sel_q;
    logic             active;
    logic [SEG_W-1:0] seg;
    logic             start;
    vec3_t            vec;

    svm3_hyst #(.UW(UW)) u_hyst (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .region_hi (angle[AW-1]),
        .unbal     (unbal),
        .thr_lo    (thr_lo),
        .thr_hi    (thr_hi),
        .sel_next  (sel_next)
    );

    svm3_seg_timer #(.TW(TW)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .t_a      (t_a),
        .t_b      (t_b),
        .t_c      (t_c),
        .load     (load),
        .seg_q    (seg),
        .start_q  (start),
        .active_q (active)
    );

    // Sequence choice is captured with the durations and held for the period.
    always_ff @(posedge clk) begin
        if (rst)
            sel_q <= 1'b0;
        else if (load)
            sel_q <= sel_next;
    end

    svm3_vec_map u_map (
        .active (active),
        .sel    (sel_q),
        .seg    (seg),
        .vec    (vec)
    );

    assign phase_a      = vec.a;
    assign phase_b      = vec.b;
    assign phase_c      = vec.c;
    assign seg_idx      = seg;
    assign period_start = start;
    assign seq_sel      = sel_q;

endmodule

// File: rtl/svm3_seq_sel_chk.sv
module svm3_seq_sel_chk #(
    parameter int AW = 8,
    parameter int TW = 8,
    parameter int UW = 10
) (
    input logic                 clk,
    input logic                 rst,
    input logic [AW-1:0]        angle,
    input logic [TW-1:0]        t_a,
    input logic [TW-1:0]        t_b,
    input logic [TW-1:0]        t_c,
    input logic signed [UW-1:0] unbal,
    input logic signed [UW-1:0] thr_lo,
    input logic signed [UW-1:0] thr_hi,
    input logic [1:0]           phase_a,
    input logic [1:0]           phase_b,
    input logic [1:0]           phase_c,
    input logic [2:0]           seg_idx,
    input logic                 period_start,
    input logic                 seq_sel
);

    logic started;

    always_ff @(posedge clk) begin
        if (rst)
            started <= 1'b0;
        else if (period_start)
            started <= 1'b1;
    end

    a_r1_phase_legal: assert property (@(posedge clk) disable iff (rst)
        (phase_a != 2'b10) && (phase_b != 2'b10) && (phase_c != 2'b10));

    a_r2_clamp_a: assert property (@(posedge clk) disable iff (rst)
        (started && !seq_sel) |-> (phase_a == 2'b01));

    a_r3_clamp_c: assert property (@(posedge clk) disable iff (rst)
        (started && seq_sel) |-> (phase_c == 2'b11));

    a_r7_mid_vector: assert property (@(posedge clk) disable iff (rst)
        (seg_idx == 3'd2) |-> (phase_a == 2'b01 && phase_b == 2'b00 && phase_c == 2'b11));

    a_r7_seg_forward: assert property (@(posedge clk) disable iff (rst)
        !period_start |-> (seg_idx >= $past(seg_idx)));

    a_r8_sel_held: assert property (@(posedge clk) disable iff (rst)
        !period_start |-> $stable(seq_sel));

    a_r9_start_seg: assert property (@(posedge clk) disable iff (rst)
        period_start |-> (seg_idx <= 3'd2));

endmodule

bind svm3_seq_sel svm3_seq_sel_chk #(.AW(AW), .TW(TW), .UW(UW)) u_chk (.*);

// File: tb/svm3_seq_sel_bench.sv
module svm3_seq_sel_bench;

    localparam int AW = 8;
    localparam int TW = 8;
    localparam int UW = 10;
    localparam int NV = 17;

    typedef struct packed {
        logic [7:0]        ang;
        logic [7:0]        ta;
        logic [7:0]        tb;
        logic [7:0]        tc;
        logic signed [9:0] unb;
        logic signed [9:0] lo;
        logic signed [9:0] hi;
        logic              sel;
    } vec_t;

    // Stimulus and expected sequence choice, walked in order (hysteresis carries over).
    localparam vec_t TBL [NV] = '{
        '{8'd40,  8'd6,   8'd4, 8'd3,  10'sd0,   -10'sd20, 10'sd20, 1'b0},
        '{8'd200, 8'd6,   8'd4, 8'd3,  10'sd5,   -10'sd20, 10'sd20, 1'b1},
        '{8'd127, 8'd5,   8'd3, 8'd2,  10'sd0,   -10'sd20, 10'sd20, 1'b0},
        '{8'd128, 8'd1,   8'd1, 8'd0,  10'sd0,   -10'sd20, 10'sd20, 1'b1},
        '{8'd200, 8'd6,   8'd4, 8'd3,  -10'sd30, -10'sd20, 10'sd20, 1'b0},
        '{8'd200, 8'd6,   8'd4, 8'd3,  -10'sd5,  -10'sd20, 10'sd20, 1'b0},
        '{8'd200, 8'd6,   8'd4, 8'd3,  10'sd0,   -10'sd20, 10'sd20, 1'b1},
        '{8'd10,  8'd6,   8'd4, 8'd3,  10'sd25,  -10'sd20, 10'sd20, 1'b1},
        '{8'd10,  8'd6,   8'd4, 8'd3,  10'sd3,   -10'sd20, 10'sd20, 1'b1},
        '{8'd10,  8'd6,   8'd4, 8'd3,  -10'sd1,  -10'sd20, 10'sd20, 1'b0},
        '{8'd10,  8'd6,   8'd4, 8'd3,  10'sd20,  -10'sd20, 10'sd20, 1'b0},
        '{8'd250, 8'd6,   8'd4, 8'd3,  -10'sd20, -10'sd20, 10'sd20, 1'b1},
        '{8'd0,   8'd0,   8'd8, 8'd0,  10'sd0,   -10'sd20, 10'sd20, 1'b0},
        '{8'd255, 8'd255, 8'd0, 8'd7,  10'sd0,   -10'sd20, 10'sd20, 1'b1},
        '{8'd10,  8'd6,   8'd4, 8'd3,  10'sd8,   -10'sd5,  10'sd5,  1'b1},
        '{8'd10,  8'd6,   8'd4, 8'd3,  10'sd8,   -10'sd20, 10'sd20, 1'b1},
        '{8'd100, 8'd6,   8'd4, 8'd3,  -10'sd6,  -10'sd5,  10'sd5,  1'b0}
    };

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic [AW-1:0]        angle = '0;
    logic [TW-1:0]        t_a = '0;
    logic [TW-1:0]        t_b = '0;
    logic [TW-1:0]        t_c = '0;
    logic signed [UW-1:0] unbal = '0;
    logic signed [UW-1:0] thr_lo = -10'sd20;
    logic signed [UW-1:0] thr_hi = 10'sd20;
    logic [1:0]           phase_a;
    logic [1:0]           phase_b;
    logic [1:0]           phase_c;
    logic [2:0]           seg_idx;
    logic                 period_start;
    logic                 seq_sel;

    int n_checks = 0;
    int n_fail   = 0;

    always #2 clk = ~clk;

    svm3_seq_sel #(.AW(AW), .TW(TW), .UW(UW)) u_svm3_seq_sel (
        .clk          (clk),
        .rst          (rst),
        .angle        (angle),
        .t_a          (t_a),
        .t_b          (t_b),
        .t_c          (t_c),
        .unbal        (unbal),
        .thr_lo       (thr_lo),
        .thr_hi       (thr_hi),
        .phase_a      (phase_a),
        .phase_b      (phase_b),
        .phase_c      (phase_c),
        .seg_idx      (seg_idx),
        .period_start (period_start),
        .seq_sel      (seq_sel)
    );

    function automatic logic [5:0] exp_vec(input logic sel, input int seg);
        logic [5:0] v;
        case (seg)
            0, 4:    v = sel ? 6'b00_11_11 : 6'b01_01_00;
            1, 3:    v = sel ? 6'b00_00_11 : 6'b01_00_00;
            2:       v = 6'b01_00_11;
            default: v = 6'b00_00_00;
        endcase
        return v;
    endfunction

    function automatic int seg_len(input vec_t e, input int s);
        case (s)
            0, 4:    return int'(e.ta) / 2;
            1, 3:    return int'(e.tb) / 2;
            default: return (e.tc == 0) ? 1 : int'(e.tc);
        endcase
    endfunction

    task automatic apply(input vec_t e);
        angle  = e.ang;
        t_a    = e.ta;
        t_b    = e.tb;
        t_c    = e.tc;
        unbal  = e.unb;
        thr_lo = e.lo;
        thr_hi = e.hi;
    endtask

    task automatic scramble(input vec_t e);
        angle = e.ang ^ 8'h80;
        t_a   = 8'd3;
        t_b   = 8'd3;
        t_c   = 8'd3;
        unbal = (e.unb < 0) ? 10'sd200 : -10'sd200;
    endtask

    // Called at the negedge in the first cycle of a period that used entry e.
    // Checks every cycle of it and ends at the first cycle of the next period.
    task automatic walk(input int idx, input vec_t e, input logic exp_sel);
        int  len;
        int  bad;
        int  j;
        logic [5:0] act;
        logic [5:0] want;
        len = 0;
        for (int s = 0; s < 5; s++) len += seg_len(e, s);
        bad = 0;
        j = 0;
        n_checks++;
        if (seq_sel !== exp_sel) begin
            n_fail++;
            $display("FAIL R4 R5 R6 entry %0d: seq_sel actual %0b expected %0b",
                     idx, seq_sel, exp_sel);
        end
        for (int s = 0; s < 5; s++) begin
            for (int k = 0; k < seg_len(e, s); k++) begin
                act  = {phase_a, phase_b, phase_c};
                want = exp_vec(exp_sel, s);
                if (bad == 0 && (act !== want || seg_idx !== 3'(s) ||
                                 period_start !== (j == 0))) begin
                    bad = 1;
                    $display("FAIL R1 R2 R3 R7 R8 R9 entry %0d cycle %0d: seg/phases/start actual %0d/%b/%0b expected %0d/%b/%0b",
                             idx, j, seg_idx, act, period_start, s, want, (j == 0));
                end
                if (j == 0 && len > 1) scramble(e);
                if (j == len - 1) apply(e);
                @(negedge clk);
                j++;
            end
        end
        if (bad == 0 && period_start !== 1'b1) begin
            bad = 1;
            $display("FAIL R9 entry %0d: next period_start actual %0b expected 1",
                     idx, period_start);
        end
        n_checks++;
        if (bad != 0) n_fail++;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: run did not complete, actual timeout expected finish");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin : main
        vec_t rv;
        apply(TBL[0]);
        repeat (3) @(negedge clk);
        // R10: outputs at reset
        n_checks++;
        if ({phase_a, phase_b, phase_c, seg_idx, period_start, seq_sel} !== '0) begin
            n_fail++;
            $display("FAIL R10 reset outputs actual %b expected 0",
                     {phase_a, phase_b, phase_c, seg_idx, period_start, seq_sel});
        end
        rst = 1'b0;
        @(negedge clk);
        n_checks++;
        if (period_start !== 1'b1) begin
            n_fail++;
            $display("FAIL R10 first period_start actual %0b expected 1", period_start);
        end

        for (int i = 0; i < NV; i++) begin
            walk(i, TBL[i], TBL[i].sel);
            if (i < NV - 1) begin
                apply(TBL[i + 1]);
                do @(negedge clk); while (period_start !== 1'b1);
            end
        end

        // R10: reset clears a held upper-charge choice back to the angle rule.
        rst = 1'b1;
        rv = '{8'd200, 8'd6, 8'd4, 8'd3, -10'sd6, -10'sd20, 10'sd20, 1'b1};
        apply(rv);
        repeat (2) @(negedge clk);
        n_checks++;
        if ({phase_a, phase_b, phase_c, seg_idx, period_start, seq_sel} !== '0) begin
            n_fail++;
            $display("FAIL R10 mid-run reset outputs actual %b expected 0",
                     {phase_a, phase_b, phase_c, seg_idx, period_start, seq_sel});
        end
        rst = 1'b0;
        @(negedge clk);
        n_checks++;
        if (period_start !== 1'b1) begin
            n_fail++;
            $display("FAIL R10 period_start after reset actual %0b expected 1", period_start);
        end
        walk(NV, rv, 1'b1);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule